// File: doc/BRIEF.md
# Deferred-Commit SRAM Write Buffer

This block sits between a processor-side request port and an on-chip SRAM array. It holds one posted write so that the processor never waits on a store. Each accepted write goes into a single pending slot. At the same clock edge, the entry that held that slot is written into the array. Nothing else moves data into the array: there is no timer and no drain when the port is idle. The only other path is an explicit flush request.

A read looks at the pending slot first. If the read address matches a valid pending entry, each byte lane with its strobe set is taken from the slot. The other lanes come from the array. Read data is registered and appears on the cycle after the request.

The block has two active-low asynchronous resets, each released synchronously. A warm reset throws away the pending entry without writing it. A cold reset does the same and also clears the read data register. Neither reset touches the array, so software can make a store survive a warm reset in three ways:
- store the same value twice;
- follow the store with any other store;
- pulse flush.

Top module: `posted_wr_sram`

## Requirements
- R1: A write request (req=1, we=1) is accepted in its own cycle with no wait state. A read of the same address on the very next cycle returns the written bytes.
- R2: The previously pending entry is written into the array only at the clock edge where a new write is accepted (or flush is raised). A pending entry stays pending through any number of idle or read cycles.
- R3: A read whose address equals a valid pending entry returns, per byte lane i (strobe bit be[i] guards data bits 8i+7..8i), the buffered byte where the entry's strobe bit is 1 and the array byte where it is 0.
- R4: A read of an address with no matching pending entry returns the array word. rdata changes only on the cycle after a read request and holds its value otherwise.
- R5: A warm reset discards the pending entry without writing it. The array keeps every committed word, so the last single write is lost.
- R6: Writing the same value to the same address twice in a row makes that value survive a following warm reset.
- R7: A flush while no write is requested writes the pending entry into the array and empties the slot. A flush in the same cycle as a write has no effect beyond that write's own commit, and the new write stays pending.
- R8: A cold reset empties the slot and drives rdata to zero. The array contents are kept.
- R9: A dummy write to any address after a real write makes the real write survive a following warm reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous assert |
| req | input | 1 | Request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| be | input | DATA_W/8 | Byte strobes for a write |
| flush | input | 1 | Commit the pending entry and empty the slot |
| rdata | output | DATA_W | Read data, valid the cycle after a read request |

## Verification
The bench fills the whole array, then sweeps all sixteen strobe patterns against one word. A forwarder that ignored the strobes, or took the array byte for the wrong lanes, would return mixed data here.

Long idle stretches are followed by a warm reset. A buffer that drained on its own would wrongly keep the last store, and one that committed on reset would wrongly hold the lost value. The bench also compares double-store, dummy-store and flushed cases against an unprotected store, and it raises flush in the same cycle as a write. A design that let that flush commit the new write would keep a word that must be lost.

A cold reset at the end checks that rdata is cleared while the array keeps its contents.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } pwb_op_e;
endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shf_q <= '0;
    else         shf_q <= shf_d;
  end

  assign srst_n = shf_q[STAGES-1];
endmodule

// File: rtl/pwb_entry.sv
module pwb_entry #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          clr_en,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic          vld,
  output logic [AW-1:0] ent_addr,
  output logic [DW-1:0] ent_data,
  output logic [BW-1:0] ent_be
);
  logic vld_d;

  always_comb begin
    vld_d = vld;
    if (cap_en)      vld_d = 1'b1;
    else if (clr_en) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      ent_addr <= in_addr;
      ent_data <= in_data;
      ent_be   <= in_be;
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (vld && ent_addr == $past(in_addr) && ent_data == $past(in_data)));

  p_no_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !cap_en && !clr_en) |=> (vld && $stable(ent_addr) && $stable(ent_data)));
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [BW-1:0] wr_be,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  import pwb_pkg::*;
  localparam int DEPTH = 1 << AW;

  for (genvar ln = 0; ln < BW; ln++) begin : g_lane
    logic [LANE_W-1:0] mem_l [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[ln]) mem_l[wr_addr] <= wr_data[ln*LANE_W +: LANE_W];
    end

    assign rd_data[ln*LANE_W +: LANE_W] = mem_l[rd_addr];
  end
endmodule

// File: rtl/pwb_fwd.sv
module pwb_fwd #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          ent_vld,
  input  logic [AW-1:0] ent_addr,
  input  logic [DW-1:0] ent_data,
  input  logic [BW-1:0] ent_be,
  output logic [DW-1:0] merged
);
  import pwb_pkg::*;
  logic hit;

  assign hit = ent_vld && (ent_addr == rd_addr);

  for (genvar ln = 0; ln < BW; ln++) begin : g_mux
    assign merged[ln*LANE_W +: LANE_W] = (hit && ent_be[ln]) ?
                                         ent_data[ln*LANE_W +: LANE_W] :
                                         arr_data[ln*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/posted_wr_sram.sv
module posted_wr_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  cold_rst_n,
  input  logic                  warm_rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   be,
  input  logic                  flush,
  output logic [DATA_W-1:0]     rdata
);
  import pwb_pkg::*;
  localparam int BE_W = DATA_W / LANE_W;

  logic cold_s_n;
  logic buf_rst_n;
  logic any_arst_n;

  assign any_arst_n = cold_rst_n & warm_rst_n;

  pwb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_cold (
    .clk(clk), .arst_n(cold_rst_n), .srst_n(cold_s_n));
  pwb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_buf (
    .clk(clk), .arst_n(any_arst_n), .srst_n(buf_rst_n));

  pwb_op_e op;
  always_comb begin
    if (!req)    op = OP_IDLE;
    else if (we) op = OP_WRITE;
    else         op = OP_READ;
  end

  logic cap_en, rd_en, clr_en, commit_en;
  logic              ent_vld;
  logic [ADDR_W-1:0] ent_addr;
  logic [DATA_W-1:0] ent_data;
  logic [BE_W-1:0]   ent_be;
  logic [DATA_W-1:0] arr_data;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdata_d;

  assign cap_en    = (op == OP_WRITE);
  assign rd_en     = (op == OP_READ);
  assign clr_en    = flush && !cap_en;
  assign commit_en = ent_vld && (cap_en || flush);

  pwb_entry #(.AW(ADDR_W), .DW(DATA_W), .BW(BE_W)) u_entry (
    .clk(clk), .rst_n(buf_rst_n), .cap_en(cap_en), .clr_en(clr_en),
    .in_addr(addr), .in_data(wdata), .in_be(be),
    .vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be));

  pwb_array #(.AW(ADDR_W), .DW(DATA_W), .BW(BE_W)) u_array (
    .clk(clk), .wr_en(commit_en), .wr_addr(ent_addr), .wr_data(ent_data),
    .wr_be(ent_be), .rd_addr(addr), .rd_data(arr_data));

  pwb_fwd #(.AW(ADDR_W), .DW(DATA_W), .BW(BE_W)) u_fwd (
    .rd_addr(addr), .arr_data(arr_data), .ent_vld(ent_vld),
    .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be),
    .merged(merged));

  always_comb begin
    rdata_d = rdata;
    if (rd_en) rdata_d = merged;
  end

  always_ff @(posedge clk or negedge cold_s_n) begin
    if (!cold_s_n) rdata <= '0;
    else           rdata <= rdata_d;
  end

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!buf_rst_n)
    !rd_en |=> $stable(rdata));

  p_fwd_full_r3: assert property (@(posedge clk) disable iff (!buf_rst_n)
    (rd_en && ent_vld && addr == ent_addr && ent_be == '1) |=> rdata == $past(ent_data));

  p_flush_clr_r7: assert property (@(posedge clk) disable iff (!buf_rst_n)
    (flush && !cap_en) |=> !ent_vld);

  p_wr_keeps_r7: assert property (@(posedge clk) disable iff (!buf_rst_n)
    (flush && cap_en) |=> ent_vld);
endmodule

// File: tb/sim_posted_wr_sram.sv
module sim_posted_wr_sram;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic cold_rst_n, warm_rst_n, req, we, flush;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [BW-1:0] be;

  always #5 clk = ~clk;

  posted_wr_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .req(req),
    .we(we), .addr(addr), .wdata(wdata), .be(be), .flush(flush), .rdata(rdata));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic          m_vld;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [BW-1:0] m_be;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nw,
                                          input logic [BW-1:0] st);
    logic [DW-1:0] r = old;
    for (int i = 0; i < BW; i++) if (st[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA5C3_0000 ^ (a * 32'h0101_0101) ^ (a << 13);
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    if (m_vld && m_addr == a) return merge(m_mem[a], m_data, m_be);
    return m_mem[a];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input logic [BW-1:0] st,
                          input bit with_flush);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d; be = st; flush = with_flush;
    @(negedge clk);
    req = 1'b0; we = 1'b0; flush = 1'b0;
    if (m_vld) m_mem[m_addr] = merge(m_mem[m_addr], m_data, m_be);
    m_vld = 1'b1; m_addr = AW'(a); m_data = d; m_be = st;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    if (m_vld) m_mem[m_addr] = merge(m_mem[m_addr], m_data, m_be);
    m_vld = 1'b0;
  endtask

  task automatic do_read(input int a, input string tag);
    logic [DW-1:0] e;
    e = exp_rd(AW'(a));
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    check(tag, rdata, e);
  endtask

  task automatic warm_pulse();
    warm_rst_n = 1'b0;
    idle(2);
    warm_rst_n = 1'b1;
    idle(4);
    m_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    cold_rst_n = 1'b0; warm_rst_n = 1'b1; req = 1'b0; we = 1'b0; flush = 1'b0;
    addr = '0; wdata = '0; be = '0; m_vld = 1'b0; m_addr = '0; m_data = '0; m_be = '0;
    for (int a = 0; a < DEPTH; a++) m_mem[a] = 'x;
    idle(3);
    cold_rst_n = 1'b1;
    idle(4);
    check("R8 rdata after cold reset", rdata, '0);

    // R1 write then immediate read forwards
    do_write(3, 32'hDEAD_BEEF, '1, 1'b0);
    do_read(3, "R1 back-to-back forward");

    // fill whole array, commit last with identical second write (R6 style)
    for (int a = 0; a < DEPTH; a++) do_write(a, pat(a), '1, 1'b0);
    do_write(DEPTH-1, pat(DEPTH-1), '1, 1'b0);
    for (int a = 0; a < DEPTH; a++) do_read(a, "R4 array sweep");

    // R3 strobe sweep on word 5
    for (int s = 0; s < 16; s++) begin
      do_write(5, 32'h1122_3344 + s * 32'h0F0F_0F0F, BW'(s), 1'b0);
      do_read(5, "R3 lane merge");
      do_read(6, "R4 neighbour unaffected");
    end

    // R4 rdata holds across idle and writes
    do_read(9, "R4 read before hold");
    held = rdata;
    idle(5);
    do_write(40, 32'h0BAD_F00D, '1, 1'b0);
    idle(2);
    check("R4 rdata held", rdata, held);

    // R2/R5 pending entry survives idle, then is lost on warm reset
    do_write(12, 32'hCAFE_0012, '1, 1'b0);
    idle(50);
    do_read(12, "R2 still pending after idle");
    warm_pulse();
    do_read(12, "R5 last write lost");
    do_read(40, "R5 committed word kept");

    // R6 identical double write
    do_write(20, 32'h2020_2020, '1, 1'b0);
    do_write(20, 32'h2020_2020, '1, 1'b0);
    warm_pulse();
    do_read(20, "R6 double write survives");

    // R9 dummy write
    do_write(21, 32'h2121_ABCD, '1, 1'b0);
    do_write(0, pat(0), '1, 1'b0);
    warm_pulse();
    do_read(21, "R9 dummy write commits");

    // R7 flush commits
    do_write(22, 32'h2222_FEED, '1, 1'b0);
    do_flush();
    warm_pulse();
    do_read(22, "R7 flush commits");

    // R7 flush with write: new write stays pending and is lost
    do_write(23, 32'h2323_0001, '1, 1'b0);
    do_write(24, 32'h2424_0002, '1, 1'b1);
    do_read(24, "R7 write with flush pending");
    warm_pulse();
    do_read(23, "R7 earlier write committed");
    do_read(24, "R7 write with flush lost");

    // R8 cold reset keeps array, clears rdata
    do_write(30, 32'h3030_3030, '1, 1'b0);
    cold_rst_n = 1'b0;
    idle(2);
    cold_rst_n = 1'b1;
    idle(4);
    m_vld = 1'b0;
    check("R8 rdata zero after cold reset", rdata, '0);
    do_read(1, "R8 array kept");
    do_read(30, "R8 pending dropped");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule